// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs one external memory transfer per machine cycle for an 8-bit controller with a 16-bit address space. The core presents a request made of an address, write data, a direction flag and a program/data space flag. It gets back a one-cycle completion pulse and, after a read, the byte that was captured from the bus. On the pin side, the upper address byte has a port of its own. The lower address byte and the data byte share one set of pins. The address is framed by an active-low address strobe, and the data is framed afterwards by a separate active-low data strobe.

Every transfer passes through the same fixed phases, one clock each: address drive with the address strobe low, address hold with the strobe high again, data setup, data strobe low, and release. A configuration register chooses whether each of the two ports carries bus signals or acts as a plain output port. In plain output mode, a port data register drives the port. The bus drive enable only ever changes while both strobes are high, so the core and an external device never drive the shared pins at the same time.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, both strobes, `pin_rw` and `pin_dm_n` are 1, `req_ready` and `rsp_done` are 0, and both ports drive zero with `pin_ad_oe` = 1 (general-purpose mode, zero port data).
- R2: A `cfg_we` write puts the high port in bus mode only when `cfg_mode` bit 7 and bit 1 are both 1. It puts the shared port in bus mode only when bit 4 is 1 and bit 3 is 0. A port that is not in bus mode drives the value last written through `gp_we`.
- R3: An accepted request makes `pin_as_n` low for exactly the first cycle after acceptance. It is followed by one hold cycle and one setup cycle with both strobes high, then `pin_ds_n` low for exactly one cycle, then one release cycle. The two strobes are never low together.
- R4: During the address phase and the hold phase, `pin_ad_out` carries address bits 7..0 with `pin_ad_oe` = 1. In bus mode, `pin_hi` carries address bits 15..8 of the last accepted request.
- R5: `pin_rw` is 0 from the address phase through the release phase of a write, and 1 at all other times. `pin_dm_n` is 0 through those phases for a data-space request and 1 otherwise.
- R6: In a write, `pin_ad_out` carries the write data with `pin_ad_oe` = 1 from the setup phase through the release phase, so the data is valid before `pin_ds_n` falls.
- R7: In a read, `pin_ad_oe` is 0 from the setup phase through the release phase. `rsp_rdata` takes the `pin_ad_in` value present in the last cycle with `pin_ds_n` low, and `rsp_done` is 1 for the single release cycle.
- R8: `pin_ad_oe` changes only in a cycle where both strobes are high and were also high in the previous cycle.
- R9: `req_ready` is 1 only when no transfer is running and the shared port is in bus mode. Without bus mode no request is accepted and both strobes stay high.
- R10: `cfg_we` and `gp_we` writes that arrive while a transfer is running have no effect.
- R11: In bus mode with no transfer running, the shared port keeps driving address bits 7..0 of the last request with `pin_ad_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_space | input | 1 | 1 = data space, 0 = program space |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last byte read |
| cfg_we | input | 1 | Mode register write |
| cfg_mode | input | MODE_W | Mode register value |
| gp_we | input | 1 | Port data register write |
| gp_hi | input | ADDR_W-DATA_W | High port data |
| gp_lo | input | DATA_W | Shared port data |
| pin_as_n | output | 1 | Address strobe, active low |
| pin_ds_n | output | 1 | Data strobe, active low |
| pin_rw | output | 1 | 0 during writes |
| pin_dm_n | output | 1 | 0 during data-space transfers |
| pin_hi | output | ADDR_W-DATA_W | High address byte or port data |
| pin_ad_out | output | DATA_W | Shared address/data output value |
| pin_ad_oe | output | 1 | Shared pin drive enable |
| pin_ad_in | input | DATA_W | Shared pin input value |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data byte, an 8-bit mode register, and decode bits 7 and 1 for the high port and bits 4 and 3 for the shared port. With these values, a handful of mode bytes covers every combination of the two port decodes, including a value that sets bit 4 together with bit 3. The bench runs writes and reads in both address spaces, back-to-back transfers, and configuration writes attempted in the middle of a transfer.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ADDR  = 3'd1,
      PH_AHOLD = 3'd2,
      PH_SETUP = 3'd3,
      PH_DSTR  = 3'd4,
      PH_REL   = 3'd5
   } xbus_phase_e;

   // phases in which the data byte (not the address) owns the shared pins
   function automatic logic phase_is_data(xbus_phase_e p);
      return (p == PH_SETUP) || (p == PH_DSTR) || (p == PH_REL);
   endfunction
endpackage

// File: rtl/xbus_port_cfg.sv
module xbus_port_cfg #(
   parameter int MODE_W     = 8,
   parameter int HI_W       = 8,
   parameter int LO_W       = 8,
   parameter int HI_SEL_A   = 7,
   parameter int HI_SEL_B   = 1,
   parameter int LO_SEL_ON  = 4,
   parameter int LO_SEL_OFF = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              cfg_we,
   input  logic [MODE_W-1:0] cfg_mode,
   input  logic              gp_we,
   input  logic [HI_W-1:0]   gp_hi,
   input  logic [LO_W-1:0]   gp_lo,
   output logic              hi_bus,
   output logic              lo_bus,
   output logic [HI_W-1:0]   gp_hi_q,
   output logic [LO_W-1:0]   gp_lo_q
);
   localparam int MAX_SEL = MODE_W - 1;

   if (HI_SEL_A > MAX_SEL || HI_SEL_B > MAX_SEL ||
       LO_SEL_ON > MAX_SEL || LO_SEL_OFF > MAX_SEL) begin : g_bad_sel
      $error("xbus_port_cfg: decode bit outside mode register");
   end
   if (LO_SEL_ON == LO_SEL_OFF) begin : g_bad_lo
      $error("xbus_port_cfg: shared port decode bits must differ");
   end

   logic cfg_unused;
   assign cfg_unused = ^cfg_mode;

   logic hi_dec, lo_dec;
   assign hi_dec = cfg_mode[HI_SEL_A] & cfg_mode[HI_SEL_B];
   assign lo_dec = cfg_mode[LO_SEL_ON] & ~cfg_mode[LO_SEL_OFF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_bus  <= 1'b0;
         lo_bus  <= 1'b0;
         gp_hi_q <= '0;
         gp_lo_q <= '0;
      end else if (!lock) begin
         if (cfg_we) begin
            hi_bus <= hi_dec;
            lo_bus <= lo_dec;
         end
         if (gp_we) begin
            gp_hi_q <= gp_hi;
            gp_lo_q <= gp_lo;
         end
      end
   end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_bus,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_data_space,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] ad_in,
   output xbus_phase_e       phase,
   output logic [ADDR_W-1:0] x_addr,
   output logic [DATA_W-1:0] x_wdata,
   output logic              x_write,
   output logic              x_dspace,
   output logic [DATA_W-1:0] rdata,
   output logic              ready,
   output logic              done
);
   xbus_phase_e phase_nx;
   logic        accept;

   assign ready  = (phase == PH_IDLE) && lo_bus;
   assign accept = ready && req_valid;
   assign done   = (phase == PH_REL);

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE:  if (accept) phase_nx = PH_ADDR;
         PH_ADDR:  phase_nx = PH_AHOLD;
         PH_AHOLD: phase_nx = PH_SETUP;
         PH_SETUP: phase_nx = PH_DSTR;
         PH_DSTR:  phase_nx = PH_REL;
         PH_REL:   phase_nx = PH_IDLE;
         default:  phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         x_addr   <= '0;
         x_wdata  <= '0;
         x_write  <= 1'b0;
         x_dspace <= 1'b0;
         rdata    <= '0;
      end else begin
         phase <= phase_nx;
         if (accept) begin
            x_addr   <= req_addr;
            x_wdata  <= req_wdata;
            x_write  <= req_write;
            x_dspace <= req_data_space;
         end
         // sample while the data strobe is still low
         if (phase == PH_DSTR && !x_write) begin
            rdata <= ad_in;
         end
      end
   end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  xbus_phase_e               phase,
   input  logic                      hi_bus,
   input  logic                      lo_bus,
   input  logic [ADDR_W-1:0]         x_addr,
   input  logic [DATA_W-1:0]         x_wdata,
   input  logic                      x_write,
   input  logic                      x_dspace,
   input  logic [ADDR_W-DATA_W-1:0]  gp_hi_q,
   input  logic [DATA_W-1:0]         gp_lo_q,
   output logic                      pin_as_n,
   output logic                      pin_ds_n,
   output logic                      pin_rw,
   output logic                      pin_dm_n,
   output logic [ADDR_W-DATA_W-1:0]  pin_hi,
   output logic [DATA_W-1:0]         pin_ad_out,
   output logic                      pin_ad_oe
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic in_xfer, data_ph;
   assign in_xfer = (phase != PH_IDLE);
   assign data_ph = phase_is_data(phase);

   assign pin_as_n = (phase != PH_ADDR);
   assign pin_ds_n = (phase != PH_DSTR);
   assign pin_rw   = ~(in_xfer & x_write);
   assign pin_dm_n = ~(in_xfer & x_dspace);

   for (genvar i = 0; i < HI_W; i++) begin : g_hi_lane
      assign pin_hi[i] = hi_bus ? x_addr[DATA_W+i] : gp_hi_q[i];
   end

   always_comb begin
      if (!lo_bus) begin
         pin_ad_out = gp_lo_q;
         pin_ad_oe  = 1'b1;
      end else if (data_ph) begin
         pin_ad_out = x_wdata;
         pin_ad_oe  = x_write;
      end else begin
         pin_ad_out = x_addr[DATA_W-1:0];
         pin_ad_oe  = 1'b1;
      end
   end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int MODE_W     = 8,
   parameter int HI_SEL_A   = 7,
   parameter int HI_SEL_B   = 1,
   parameter int LO_SEL_ON  = 4,
   parameter int LO_SEL_OFF = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic                     req_data_space,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     rsp_done,
   output logic [DATA_W-1:0]        rsp_rdata,
   input  logic                     cfg_we,
   input  logic [MODE_W-1:0]        cfg_mode,
   input  logic                     gp_we,
   input  logic [ADDR_W-DATA_W-1:0] gp_hi,
   input  logic [DATA_W-1:0]        gp_lo,
   output logic                     pin_as_n,
   output logic                     pin_ds_n,
   output logic                     pin_rw,
   output logic                     pin_dm_n,
   output logic [ADDR_W-DATA_W-1:0] pin_hi,
   output logic [DATA_W-1:0]        pin_ad_out,
   output logic                     pin_ad_oe,
   input  logic [DATA_W-1:0]        pin_ad_in
);
   localparam int HI_W = ADDR_W - DATA_W;

   if (DATA_W < 1 || HI_W < 1) begin : g_bad_width
      $error("xbus_ctrl: address must be wider than the data byte");
   end

   xbus_phase_e       phase;
   logic              hi_bus, lo_bus;
   logic [HI_W-1:0]   gp_hi_q;
   logic [DATA_W-1:0] gp_lo_q;
   logic [ADDR_W-1:0] x_addr;
   logic [DATA_W-1:0] x_wdata;
   logic              x_write, x_dspace;
   logic              busy;

   assign busy = (phase != PH_IDLE);

   xbus_port_cfg #(
      .MODE_W(MODE_W), .HI_W(HI_W), .LO_W(DATA_W),
      .HI_SEL_A(HI_SEL_A), .HI_SEL_B(HI_SEL_B),
      .LO_SEL_ON(LO_SEL_ON), .LO_SEL_OFF(LO_SEL_OFF)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .lock(busy),
      .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .gp_we(gp_we), .gp_hi(gp_hi), .gp_lo(gp_lo),
      .hi_bus(hi_bus), .lo_bus(lo_bus),
      .gp_hi_q(gp_hi_q), .gp_lo_q(gp_lo_q)
   );

   xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .lo_bus(lo_bus),
      .req_valid(req_valid), .req_write(req_write),
      .req_data_space(req_data_space), .req_addr(req_addr),
      .req_wdata(req_wdata), .ad_in(pin_ad_in),
      .phase(phase), .x_addr(x_addr), .x_wdata(x_wdata),
      .x_write(x_write), .x_dspace(x_dspace),
      .rdata(rsp_rdata), .ready(req_ready), .done(rsp_done)
   );

   xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .phase(phase), .hi_bus(hi_bus), .lo_bus(lo_bus),
      .x_addr(x_addr), .x_wdata(x_wdata), .x_write(x_write),
      .x_dspace(x_dspace), .gp_hi_q(gp_hi_q), .gp_lo_q(gp_lo_q),
      .pin_as_n(pin_as_n), .pin_ds_n(pin_ds_n), .pin_rw(pin_rw),
      .pin_dm_n(pin_dm_n), .pin_hi(pin_hi),
      .pin_ad_out(pin_ad_out), .pin_ad_oe(pin_ad_oe)
   );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic pin_as_n,
   input logic pin_ds_n,
   input logic pin_rw,
   input logic pin_dm_n,
   input logic pin_ad_oe,
   input logic req_ready,
   input logic rsp_done
);
   assert_as_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_as_n |=> pin_as_n);
   assert_ds_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_ds_n |=> pin_ds_n);
   assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pin_as_n || pin_ds_n);
   assert_idle_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (pin_rw && pin_dm_n));
   assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_ds_n && !pin_rw) |-> pin_ad_oe);
   assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_ds_n && pin_rw) |-> !pin_ad_oe);
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   assert_oe_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_ad_oe) |-> (pin_as_n && pin_ds_n && $past(pin_as_n) && $past(pin_ds_n)));
   assert_ready_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (pin_as_n && pin_ds_n));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pin_as_n(pin_as_n), .pin_ds_n(pin_ds_n),
   .pin_rw(pin_rw), .pin_dm_n(pin_dm_n), .pin_ad_oe(pin_ad_oe),
   .req_ready(req_ready), .rsp_done(rsp_done)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_data_space = 0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        cfg_we = 0, gp_we = 0;
   logic [7:0]  cfg_mode = '0, gp_hi = '0, gp_lo = '0, pin_ad_in = '0;
   logic        req_ready, rsp_done, pin_as_n, pin_ds_n, pin_rw, pin_dm_n, pin_ad_oe;
   logic [7:0]  rsp_rdata, pin_hi, pin_ad_out;

   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   xbus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_data_space(req_data_space),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
      .rsp_rdata(rsp_rdata), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .gp_we(gp_we), .gp_hi(gp_hi), .gp_lo(gp_lo),
      .pin_as_n(pin_as_n), .pin_ds_n(pin_ds_n), .pin_rw(pin_rw),
      .pin_dm_n(pin_dm_n), .pin_hi(pin_hi), .pin_ad_out(pin_ad_out),
      .pin_ad_oe(pin_ad_oe), .pin_ad_in(pin_ad_in)
   );

   // behavioural reference: phase counter 0..5 and latched request
   int          m_ph;
   bit          m_hib, m_lob, m_wr, m_ds;
   logic [7:0]  m_ghi, m_glo, m_wd, m_rd;
   logic [15:0] m_addr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_hib = 0; m_lob = 0; m_wr = 0; m_ds = 0;
         m_ghi = 0; m_glo = 0; m_wd = 0; m_rd = 0; m_addr = 0;
      end else if (m_ph == 0) begin
         if (req_valid && m_lob) begin
            m_addr = req_addr; m_wd = req_wdata; m_wr = req_write;
            m_ds = req_data_space; m_ph = 1;
         end
         if (cfg_we) begin
            m_hib = cfg_mode[7] && cfg_mode[1];
            m_lob = cfg_mode[4] && !cfg_mode[3];
         end
         if (gp_we) begin m_ghi = gp_hi; m_glo = gp_lo; end
      end else begin
         if (m_ph == 4 && !m_wr) m_rd = pin_ad_in;
         m_ph = (m_ph == 5) ? 0 : m_ph + 1;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit e_oe;
         e_oe = !m_lob || m_wr || (m_ph < 3);
         chk("R3 as_n", pin_as_n, m_ph != 1);
         chk("R3 ds_n", pin_ds_n, m_ph != 4);
         chk("R5 rw", pin_rw, !(m_ph != 0 && m_wr));
         chk("R5 dm_n", pin_dm_n, !(m_ph != 0 && m_ds));
         chk(m_hib ? "R4 hi addr" : "R2 hi port", pin_hi, m_hib ? m_addr[15:8] : m_ghi);
         chk((m_ph >= 3 && !m_wr) ? "R7 oe" : "R8 oe", pin_ad_oe, e_oe);
         if (e_oe) begin
            if (!m_lob)                    chk("R2 lo port", pin_ad_out, m_glo);
            else if (m_ph == 0)            chk("R11 idle ad", pin_ad_out, m_addr[7:0]);
            else if (m_ph < 3)             chk("R4 addr lo", pin_ad_out, m_addr[7:0]);
            else                           chk("R6 wdata", pin_ad_out, m_wd);
         end
         chk("R9 ready", req_ready, (m_ph == 0) && m_lob);
         chk("R7 done", rsp_done, m_ph == 5);
         chk("R7 rdata", rsp_rdata, m_rd);
      end
   end

   task automatic tick(); @(posedge clk); #1; endtask

   task automatic set_mode(input logic [7:0] v);
      cfg_mode = v; cfg_we = 1; tick(); cfg_we = 0;
   endtask

   task automatic set_port(input logic [7:0] h, input logic [7:0] l);
      gp_hi = h; gp_lo = l; gp_we = 1; tick(); gp_we = 0;
   endtask

   task automatic xfer(input bit wr, input bit dsp, input logic [15:0] a,
                       input logic [7:0] d, input logic [7:0] rd_bus);
      req_write = wr; req_data_space = dsp; req_addr = a; req_wdata = d;
      pin_ad_in = rd_bus; req_valid = 1;
      while (!req_ready) tick();
      tick();
      req_valid = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 as_n", pin_as_n, 1); chk("R1 ds_n", pin_ds_n, 1);
      chk("R1 rw", pin_rw, 1);     chk("R1 dm_n", pin_dm_n, 1);
      chk("R1 ready", req_ready, 0); chk("R1 done", rsp_done, 0);
      chk("R1 oe", pin_ad_oe, 1);  chk("R1 ad", pin_ad_out, 0);
      chk("R1 hi", pin_hi, 0);
      @(posedge clk); #1 rst_n = 1;
      tick();
      // R2 general-purpose ports, R9 requests refused
      set_port(8'hA5, 8'h3C);
      req_valid = 1; req_addr = 16'h4411; repeat (4) tick(); req_valid = 0;
      set_mode(8'h9A);                        // bit 3 set: shared port stays plain
      req_valid = 1; repeat (3) tick(); req_valid = 0;
      // full bus mode
      set_mode(8'h92);
      tick();
      xfer(1, 1, 16'h12F0, 8'h5A, 8'h00);     // R5 R6 data-space write
      xfer(0, 0, 16'hBEEF, 8'h00, 8'hC3);     // R7 program read
      xfer(0, 1, 16'h0001, 8'h00, 8'h7E);     // back-to-back
      // R10: config and port writes during a transfer
      req_write = 1; req_data_space = 0; req_addr = 16'h8D2C; req_wdata = 8'h96;
      req_valid = 1;
      while (!req_ready) tick();
      tick(); req_valid = 0;
      cfg_mode = 8'h00; cfg_we = 1; gp_hi = 8'h11; gp_lo = 8'h22; gp_we = 1;
      tick(); cfg_we = 0; gp_we = 0;
      repeat (5) tick();
      @(negedge clk);
      chk("R10 mode kept", req_ready, 1);
      chk("R10 hi kept", pin_hi, 8'h8D);
      set_mode(8'h12);                        // high port plain, shared port bus
      chk("R10 port kept", pin_hi, 8'hA5);
      for (int i = 0; i < 24; i++) begin
         xfer(i[0], i[1], 16'(i * 16'h1357 + 16'h0F0F), 8'(i * 37), 8'(i * 91 + 5));
      end
      set_mode(8'h92);
      for (int i = 0; i < 12; i++) begin
         xfer(i[1], i[0], 16'(i * 16'h2B1D), 8'(i * 13 + 1), 8'(255 - i * 17));
      end
      repeat (8) tick();
      set_mode(8'h00);
      set_port(8'h0F, 8'hF0);
      repeat (3) tick();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule